// File: doc/BRIEF.md
# General-purpose I/O port with pin level resolution

This block is a sixteen-pin I/O port controlled through a 32-bit register interface with single-cycle access. Each pin has four configuration fields: a 2-bit direction code, a 1-bit driver style (push-pull or open-drain), a 2-bit pull selection and an output data bit. The port works out the level of every pin from four sources: that configuration, an external driver, a per-pin flag that records whether the external driver is still attached, and the pull. It drives the results on a 16-bit level output to a system controller. Software reads the same levels from a read-only register.

The external side changes a pin's external drive with a one-cycle strobe that carries a pin index and a level. When the port takes a pin as an output, it detaches the external driver from that pin. Detachment follows the driver style. A push-pull output always detaches. An open-drain output detaches only an external high. Two write-only registers update output data bits without a read-modify-write. One holds separate set and clear halves; the other only clears. Reset values are parameters, so that several ports on one chip can come out of reset differently. The system maps port `p` pin `i` to controller line `p*16+i` by concatenating the level outputs.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and pull registers hold the parameters MODE_RST and PULL_RST, and the driver-style and output data registers read 0. Every pin starts detached from its external driver, with the external level taken as 0.
- R2: The direction register holds 2 bits for pin i at bits [2i+1:2i]. Code 1 makes the pin an output. Codes 0, 2 and 3 all resolve the pin as an input, with identical behaviour.
- R3: The pull register holds 2 bits for pin i at bits [2i+1:2i]. A resolved input with no attached external driver reads 1 for code 1 (pull-up) and 0 for code 2 (pull-down). For codes 0 and 3 it reads bit i of the parameter FLOAT_LVL.
- R4: A drive strobe attaches the external driver to the addressed pin and records its level. If that pin is not an output, it then reads that level.
- R5: A push-pull output pin (style bit 0) reads its output data bit and stays detached from its external driver. Drive strobes on it leave its level unchanged. Once it goes back to input, it stays detached until the next strobe.
- R6: An open-drain output pin (style bit 1) with output data 0 reads 0. With output data 1 it is released and resolves like an input. An external high on an open-drain output is detached. An external low stays attached, so the pin reads 0 even when its output data bit is 1.
- R7: Output data written while a pin is an input is kept, and drives the pin as soon as the pin becomes an output.
- R8: A write to offset 0x18 sets output data bits given by wdata[15:0] and clears those given by wdata[31:16]. Where both the set and the clear bit are 1 for a pin, the set wins.
- R9: A write to offset 0x28 clears output data bits given by wdata[15:0].
- R10: Register offsets are 0x00 direction, 0x04 driver style, 0x0C pull, 0x10 input levels, 0x14 output data. A write to 0x10 changes nothing. Reads of 0x18, 0x28 and of unmapped offsets return 0.
- R11: The level output and a read of offset 0x10 both show the resolved levels. These reflect a write or drive strobe in the cycle after the clock edge that captures it.
- R12: The driver-style register holds 1 bit per pin at bit i and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_vld_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as a read access |
| drv_vld_i | input | 1 | External drive strobe |
| drv_pin_i | input | 4 | Pin index of the strobe |
| drv_lvl_i | input | 1 | Level of the external drive |
| lvl_o | output | 16 | Resolved level of each pin, toward the system controller |

## Verification
A wrong attach flag or a wrong stored external level shows nothing at once. It reaches the ports only when the pin is next resolved as an input or as a released open-drain output. The bench therefore returns pins to input after each output phase, and it compares the level output with a behavioural model on every clock. A wrong output data bit or a wrong configuration field shows up on the level output one cycle after the write that caused it, or on the next readback. Random traffic over all register offsets and drive strobes makes sure such hidden state is eventually exposed.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int CLR_LSB = DW / 2;

  localparam logic [AW-1:0] OFF_MODE  = 6'h00;
  localparam logic [AW-1:0] OFF_STYLE = 6'h04;
  localparam logic [AW-1:0] OFF_PULL  = 6'h0C;
  localparam logic [AW-1:0] OFF_LVL   = 6'h10;
  localparam logic [AW-1:0] OFF_DOUT  = 6'h14;
  localparam logic [AW-1:0] OFF_SETCL = 6'h18;
  localparam logic [AW-1:0] OFF_CLR   = 6'h28;

  localparam logic [1:0] MODE_OUT = 2'd1;
  localparam logic [1:0] PULL_UP  = 2'd1;
  localparam logic [1:0] PULL_DN  = 2'd2;

  // level of one pin from its configuration and external attachment
  function automatic logic pin_level(logic [1:0] md, logic [1:0] pl, logic od,
                                     logic dat, logic det, logic ext, logic flt);
    if (md == MODE_OUT && !od) return dat;
    if (md == MODE_OUT && !dat) return 1'b0;
    if (!det) return ext;
    case (pl)
      PULL_UP: return 1'b1;
      PULL_DN: return 1'b0;
      default: return flt;
    endcase
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter logic [2*NPINS-1:0] MODE_RST = '1,
  parameter logic [2*NPINS-1:0] PULL_RST = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_vld_i,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [2*NPINS-1:0] mode_q_o,
  output logic [2*NPINS-1:0] pull_q_o,
  output logic [NPINS-1:0]   style_q_o,
  output logic [NPINS-1:0]   dout_q_o,
  output logic [NPINS-1:0]   out_nxt_o,
  output logic [NPINS-1:0]   od_nxt_o
);
  localparam int FW = 2 * NPINS;

  logic wr;
  logic hit_mode, hit_style, hit_pull, hit_dout, hit_setcl, hit_clr;
  logic [NPINS-1:0] set_m, clr_m;
  logic [FW-1:0]    mode_d, pull_d;
  logic [NPINS-1:0] style_d, dout_d;

  assign wr        = bus_vld_i & bus_we_i;
  assign hit_mode  = wr && (bus_addr_i == OFF_MODE);
  assign hit_style = wr && (bus_addr_i == OFF_STYLE);
  assign hit_pull  = wr && (bus_addr_i == OFF_PULL);
  assign hit_dout  = wr && (bus_addr_i == OFF_DOUT);
  assign hit_setcl = wr && (bus_addr_i == OFF_SETCL);
  assign hit_clr   = wr && (bus_addr_i == OFF_CLR);
  assign set_m     = bus_wdata_i[NPINS-1:0];
  assign clr_m     = bus_wdata_i[CLR_LSB +: NPINS];

  always_comb begin
    mode_d  = hit_mode  ? bus_wdata_i[FW-1:0]    : mode_q_o;
    pull_d  = hit_pull  ? bus_wdata_i[FW-1:0]    : pull_q_o;
    style_d = hit_style ? bus_wdata_i[NPINS-1:0] : style_q_o;
    dout_d  = dout_q_o;
    if (hit_dout)       dout_d = bus_wdata_i[NPINS-1:0];
    else if (hit_setcl) dout_d = (dout_q_o & ~clr_m) | set_m;  // set wins
    else if (hit_clr)   dout_d = dout_q_o & ~set_m;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o  <= MODE_RST;
      pull_q_o  <= PULL_RST;
      style_q_o <= '0;
      dout_q_o  <= '0;
    end else begin
      mode_q_o  <= mode_d;
      pull_q_o  <= pull_d;
      style_q_o <= style_d;
      dout_q_o  <= dout_d;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_nxt
    assign out_nxt_o[i] = (mode_d[2*i +: 2] == MODE_OUT);
  end
  assign od_nxt_o = style_d;
endmodule

// File: rtl/gpio_link.sv
module gpio_link #(
  parameter int NPINS = 16,
  parameter int PIN_W = $clog2(NPINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drv_vld_i,
  input  logic [PIN_W-1:0] drv_pin_i,
  input  logic             drv_lvl_i,
  input  logic [NPINS-1:0] out_nxt_i,
  input  logic [NPINS-1:0] od_nxt_i,
  output logic [NPINS-1:0] det_q_o,
  output logic [NPINS-1:0] ext_q_o
);
  logic [NPINS-1:0] det_d, ext_d;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic hit;
    assign hit = drv_vld_i && (drv_pin_i == PIN_W'(i));
    always_comb begin
      ext_d[i] = hit ? drv_lvl_i : ext_q_o[i];
      det_d[i] = hit ? 1'b0 : det_q_o[i];
      // port-owned pin: push-pull drops any driver, open-drain drops a high
      if (out_nxt_i[i] && (!od_nxt_i[i] || ext_d[i])) det_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q_o <= '1;
      ext_q_o <= '0;
    end else begin
      det_q_o <= det_d;
      ext_q_o <= ext_d;
    end
  end
endmodule

// File: rtl/gpio_resolve.sv
module gpio_resolve
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter logic [NPINS-1:0] FLOAT_LVL = '0
) (
  input  logic [2*NPINS-1:0] mode_i,
  input  logic [2*NPINS-1:0] pull_i,
  input  logic [NPINS-1:0]   style_i,
  input  logic [NPINS-1:0]   dout_i,
  input  logic [NPINS-1:0]   det_i,
  input  logic [NPINS-1:0]   ext_i,
  output logic [NPINS-1:0]   lvl_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign lvl_o[i] = pin_level(mode_i[2*i +: 2], pull_i[2*i +: 2], style_i[i],
                                dout_i[i], det_i[i], ext_i[i], FLOAT_LVL[i]);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter logic [2*NPINS-1:0] MODE_RST = '1,
  parameter logic [2*NPINS-1:0] PULL_RST = '0,
  parameter logic [NPINS-1:0] FLOAT_LVL = '0,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_vld_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             drv_vld_i,
  input  logic [PIN_W-1:0] drv_pin_i,
  input  logic             drv_lvl_i,
  output logic [NPINS-1:0] lvl_o
);
  logic [2*NPINS-1:0] mode_q, pull_q;
  logic [NPINS-1:0]   style_q, dout_q, out_nxt, od_nxt, det_q, ext_q;

  gpio_regs #(.NPINS(NPINS), .MODE_RST(MODE_RST), .PULL_RST(PULL_RST)) i_regs (
    .clk_i, .rst_ni, .bus_vld_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .mode_q_o(mode_q), .pull_q_o(pull_q), .style_q_o(style_q), .dout_q_o(dout_q),
    .out_nxt_o(out_nxt), .od_nxt_o(od_nxt)
  );

  gpio_link #(.NPINS(NPINS), .PIN_W(PIN_W)) i_link (
    .clk_i, .rst_ni, .drv_vld_i, .drv_pin_i, .drv_lvl_i,
    .out_nxt_i(out_nxt), .od_nxt_i(od_nxt), .det_q_o(det_q), .ext_q_o(ext_q)
  );

  gpio_resolve #(.NPINS(NPINS), .FLOAT_LVL(FLOAT_LVL)) i_resolve (
    .mode_i(mode_q), .pull_i(pull_q), .style_i(style_q), .dout_i(dout_q),
    .det_i(det_q), .ext_i(ext_q), .lvl_o
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_vld_i && !bus_we_i) begin
      case (bus_addr_i)
        OFF_MODE:  bus_rdata_o = DW'(mode_q);
        OFF_STYLE: bus_rdata_o = DW'(style_q);
        OFF_PULL:  bus_rdata_o = DW'(pull_q);
        OFF_LVL:   bus_rdata_o = DW'(lvl_o);
        OFF_DOUT:  bus_rdata_o = DW'(dout_q);
        default:   bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int PIN_W = $clog2(NPINS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_vld_i,
  input logic               bus_we_i,
  input logic [AW-1:0]      bus_addr_i,
  input logic [DW-1:0]      bus_wdata_i,
  input logic [DW-1:0]      bus_rdata_o,
  input logic               drv_vld_i,
  input logic [PIN_W-1:0]   drv_pin_i,
  input logic               drv_lvl_i,
  input logic [NPINS-1:0]   lvl_o,
  input logic [2*NPINS-1:0] mode_q,
  input logic [NPINS-1:0]   style_q,
  input logic [NPINS-1:0]   dout_q,
  input logic [NPINS-1:0]   det_q
);
  logic [NPINS-1:0] is_out;
  logic rd, wr;
  for (genvar i = 0; i < NPINS; i++) begin : g_out
    assign is_out[i] = (mode_q[2*i +: 2] == MODE_OUT);
  end
  assign rd = bus_vld_i && !bus_we_i;
  assign wr = bus_vld_i && bus_we_i;

  p_pp_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((is_out & ~style_q) & (lvl_o ^ dout_q)) == '0);
  p_pp_detach_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((is_out & ~style_q) & ~det_q) == '0);
  p_od_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_out & style_q & ~dout_q & lvl_o) == '0);
  p_drive_in_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_vld_i && !is_out[drv_pin_i] && !(wr && bus_addr_i == OFF_MODE))
    |=> lvl_o[$past(drv_pin_i)] == $past(drv_lvl_i));
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == OFF_SETCL)
    |=> (dout_q & $past(bus_wdata_i[NPINS-1:0])) == $past(bus_wdata_i[NPINS-1:0]));
  p_clr_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == OFF_CLR) |=> (dout_q & $past(bus_wdata_i[NPINS-1:0])) == '0);
  p_wo_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (bus_addr_i == OFF_SETCL || bus_addr_i == OFF_CLR)) |-> bus_rdata_o == '0);
  p_lvl_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == OFF_LVL) |-> bus_rdata_o == DW'(lvl_o));
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .PIN_W(PIN_W)) i_chk (
  .clk_i, .rst_ni, .bus_vld_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
  .drv_vld_i, .drv_pin_i, .drv_lvl_i, .lvl_o,
  .mode_q, .style_q, .dout_q, .det_q
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  localparam logic [31:0] MRST = 32'hABFF_FFFF;
  localparam logic [31:0] PRST = 32'h6400_0000;
  localparam logic [15:0] FLT  = 16'h0000;

  logic clk = 0, rst_n = 0;
  logic vld = 0, we = 0, dlvl = 0, dvld = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0] dpin = '0;
  logic [15:0] lvl;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port #(.MODE_RST(MRST), .PULL_RST(PRST), .FLOAT_LVL(FLT)) i_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .bus_vld_i(vld), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .drv_vld_i(dvld), .drv_pin_i(dpin),
    .drv_lvl_i(dlvl), .lvl_o(lvl)
  );

  // behavioural reference
  bit [1:0] m_mode[16], m_pull[16];
  bit m_st[16], m_do[16], m_det[16], m_ext[16];

  function automatic bit m_pin(int i);
    if (m_mode[i] == 2'd1 && !m_st[i]) return m_do[i];
    if (m_mode[i] == 2'd1 && !m_do[i]) return 1'b0;
    if (!m_det[i]) return m_ext[i];
    if (m_pull[i] == 2'd1) return 1'b1;
    if (m_pull[i] == 2'd2) return 1'b0;
    return FLT[i];
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    logic [31:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      case (a)
        6'h00: r[2*i +: 2] = m_mode[i];
        6'h04: r[i] = m_st[i];
        6'h0C: r[2*i +: 2] = m_pull[i];
        6'h10: r[i] = m_pin(i);
        6'h14: r[i] = m_do[i];
        default: ;
      endcase
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_mode[i] = MRST[2*i +: 2]; m_pull[i] = PRST[2*i +: 2];
        m_st[i] = 0; m_do[i] = 0; m_det[i] = 1; m_ext[i] = 0;
      end
    end else begin
      chk("R11 per-cycle level", {16'h0, lvl}, m_read(6'h10));
      if (vld && we) begin
        for (int i = 0; i < 16; i++) begin
          case (addr)
            6'h00: m_mode[i] = wdata[2*i +: 2];
            6'h04: m_st[i] = wdata[i];
            6'h0C: m_pull[i] = wdata[2*i +: 2];
            6'h14: m_do[i] = wdata[i];
            6'h18: if (wdata[i]) m_do[i] = 1; else if (wdata[16+i]) m_do[i] = 0;
            6'h28: if (wdata[i]) m_do[i] = 0;
            default: ;
          endcase
        end
      end
      if (dvld) begin m_ext[dpin] = dlvl; m_det[dpin] = 0; end
      for (int i = 0; i < 16; i++)
        if (m_mode[i] == 2'd1 && (!m_st[i] || m_ext[i])) m_det[i] = 1;
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); vld = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); vld = 0; we = 0;
  endtask

  task automatic rd(logic [5:0] a, string tag);
    @(negedge clk); vld = 1; we = 0; addr = a;
    #1 chk(tag, rdata, m_read(a));
    @(negedge clk); vld = 0;
  endtask

  task automatic drv(int p, bit l);
    @(negedge clk); dvld = 1; dpin = 4'(p); dlvl = l;
    @(negedge clk); dvld = 0;
  endtask

  task automatic set_mode(int p, bit [1:0] c);
    logic [31:0] v = m_read(6'h00); v[2*p +: 2] = c; wr(6'h00, v);
  endtask
  task automatic set_pull(int p, bit [1:0] c);
    logic [31:0] v = m_read(6'h0C); v[2*p +: 2] = c; wr(6'h0C, v);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] offs[7] = '{6'h00, 6'h04, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h28};
    #23 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset levels", {16'h0, lvl}, 32'h0000_A000);
    rd(6'h00, "R1 mode reset"); rd(6'h0C, "R1 pull reset");
    rd(6'h04, "R1 style reset"); rd(6'h14, "R1 dout reset");
    // R7 data kept in input mode
    wr(6'h14, 32'h0000_0020);
    chk("R7 dout ignored while input", {31'h0, lvl[5]}, 32'h0);
    set_mode(5, 2'd1);
    chk("R7 R5 kept dout drives pin", {31'h0, lvl[5]}, 32'h1);
    wr(6'h14, 32'h0);
    chk("R5 push-pull follows dout", {31'h0, lvl[5]}, 32'h0);
    // R2 / R3 non-output codes resolve as input
    set_mode(5, 2'd2); set_pull(5, 2'd1);
    chk("R2 R3 code2 pull-up", {31'h0, lvl[5]}, 32'h1);
    set_mode(5, 2'd3);
    chk("R2 code3 pull-up", {31'h0, lvl[5]}, 32'h1);
    set_pull(5, 2'd2);
    chk("R3 pull-down", {31'h0, lvl[5]}, 32'h0);
    set_pull(5, 2'd1); set_pull(5, 2'd3);
    chk("R3 code3 float level", {31'h0, lvl[5]}, 32'h0);
    // R4 external drive on input
    set_mode(6, 2'd0);
    drv(6, 1); chk("R4 drive high", {31'h0, lvl[6]}, 32'h1);
    drv(6, 0); chk("R4 drive low", {31'h0, lvl[6]}, 32'h0);
    drv(6, 1);
    // R5 push-pull detaches
    set_mode(6, 2'd1);
    chk("R5 pp detaches high driver", {31'h0, lvl[6]}, 32'h0);
    drv(6, 1);
    chk("R5 drive on pp ignored", {31'h0, lvl[6]}, 32'h0);
    set_mode(6, 2'd0);
    chk("R5 stays detached after input", {31'h0, lvl[6]}, 32'h0);
    // R6 / R12 open-drain
    drv(4, 1); chk("R4 pin4 high", {31'h0, lvl[4]}, 32'h1);
    wr(6'h04, 32'h0000_0010); rd(6'h04, "R12 style readback");
    set_mode(4, 2'd1);
    chk("R6 od detaches high", {31'h0, lvl[4]}, 32'h0);
    drv(4, 1); chk("R6 od high drive ignored", {31'h0, lvl[4]}, 32'h0);
    wr(6'h18, 32'h0000_0010);
    chk("R6 od released floats", {31'h0, lvl[4]}, 32'h0);
    set_pull(4, 2'd1);
    chk("R6 od released pull-up", {31'h0, lvl[4]}, 32'h1);
    drv(4, 0);
    chk("R6 od external low wins", {31'h0, lvl[4]}, 32'h0);
    // R8 / R9 atomic updates
    wr(6'h18, 32'h0004_0004); rd(6'h14, "R8 set wins");
    chk("R8 set wins literal", m_read(6'h14) & 32'h4, 32'h4);
    wr(6'h18, 32'h0004_0300); rd(6'h14, "R8 set and clear");
    wr(6'h28, 32'h0000_0110); rd(6'h14, "R9 clear only");
    // R10 map corners
    wr(6'h10, 32'hFFFF_FFFF); rd(6'h10, "R10 R11 level read after ignored write");
    rd(6'h18, "R10 setclr reads 0"); rd(6'h28, "R10 clr reads 0");
    rd(6'h08, "R10 unmapped reads 0");
    // random traffic
    for (int k = 0; k < 600; k++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) drv(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
      else if (op == 1) rd(offs[$urandom_range(0, 6)], "R10 random read");
      else wr(offs[$urandom_range(0, 6)], $urandom());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule